// File: doc/BRIEF.md
# DMA Transfer Counter with Half-Way Flag

This block keeps the remaining transfer count of a single DMA channel. It also raises a sticky status flag once the transfer has reached its half-way point. Software writes the count through a small register port before it enables the channel. On the rising edge of the channel enable, the block copies the current count into a shadow register as the starting value. Each transfer-done strobe then lowers the live count by one. A decrement that leaves the count at or below half of the starting value (the starting value shifted right by one) sets the flag.

Four events end the run: a non-maskable interrupt, a bus address error, the channel enable falling, and the master enable falling. After any of them, decrements stop until the channel enable rises again. The flag cannot be set by software. Software clears it with a handshake: it reads the flag as 1, then writes 0 to it. An enable bit gates a level interrupt request that follows the flag.

Top module: `dma_half_counter`

## Requirements
- R1: After reset the count reads 0, the flag (control bit 0) reads 0, the interrupt enable (control bit 1) reads 0 and `irq` is low.
- R2: A write to address 0 loads the count, and a read of address 0 returns it. A read of address 1 returns the flag in bit 0 and the interrupt enable in bit 1, with all other bits zero.
- R3: The rising edge of `chan_en` latches the count as the starting value, provided `mst_en` is high. Each `xfer_done` strobe after that lowers the count by one. No strobe changes the count while `chan_en` or `mst_en` is low.
- R4: The count stops at zero. A strobe at zero neither wraps the count nor sets the flag.
- R5: The flag sets on the decrement that leaves the count less than or equal to floor(start/2).
- R6: A pulse on `nmi` or `addr_err`, or a falling edge of `chan_en` or `mst_en`, blocks all further decrements until `chan_en` rises again. A run ended this way before the half-way point leaves the flag at 0.
- R7: Once set, the flag stays at 1 through any of the events in R6.
- R8: The flag is cleared only by a write to address 1 with bit 0 equal to 0 that follows a read of address 1 which returned the flag as 1. Any write to address 1 uses up that read. A write of 0 without such a read has no effect. Writing 1 never sets the flag.
- R9: `irq` is high exactly when both the flag and the interrupt enable are 1.
- R10: `irq` falls in the cycle after the write that clears the flag, or after the write that sets the enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 count, 1 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register |
| chan_en | input | 1 | Channel enable |
| mst_en | input | 1 | Master enable |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| nmi | input | 1 | Non-maskable interrupt abort |
| addr_err | input | 1 | Address error abort |
| irq | output | 1 | Half-way interrupt request, level |

## Verification
The bench builds the block with CNT_W = 8, so the zero-extended control read and the full count field are both exercised. The short counts it uses bring these cases within reach in a few cycles:
- even and odd starting values, which sit on either side of the floored half;
- a starting value of 1, where the half is 0;
- a starting value of 0, where the count cannot move;
- a run past zero.

Aborts are applied both before and after the half-way point. The run is then restarted with a re-latched, smaller starting value.

// File: rtl/dma_half_counter.sv
module dma_half_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             chan_en,
  input  logic             mst_en,
  input  logic             xfer_done,
  input  logic             nmi,
  input  logic             addr_err,
  output logic             irq
);
  localparam logic SEL_CNT = 1'b0;
  localparam logic SEL_CTL = 1'b1;

  logic [CNT_W-1:0] cnt, start_q;
  logic flag, ie, armed, run, chan_q, mst_q;

  wire chan_rise = chan_en & ~chan_q;
  wire abort     = nmi | addr_err | (chan_q & ~chan_en) | (mst_q & ~mst_en);
  wire wr_cnt    = reg_wr & (reg_addr == SEL_CNT);
  wire wr_ctl    = reg_wr & (reg_addr == SEL_CTL);
  wire rd_ctl    = reg_rd & (reg_addr == SEL_CTL);
  wire dec       = xfer_done & run & chan_en & mst_en & ~abort & (cnt != '0);
  wire [CNT_W-1:0] cnt_nx = cnt - 1'b1;
  wire hit       = dec & (cnt_nx <= (start_q >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      start_q <= '0;
      flag    <= 1'b0;
      ie      <= 1'b0;
      armed   <= 1'b0;
      run     <= 1'b0;
      chan_q  <= 1'b0;
      mst_q   <= 1'b0;
    end else begin
      chan_q <= chan_en;
      mst_q  <= mst_en;
      if (chan_rise) start_q <= cnt;
      if (abort) run <= 1'b0;
      else if (chan_rise && mst_en) run <= 1'b1;
      if (wr_cnt) cnt <= reg_wdata;
      else if (dec) cnt <= cnt_nx;
      if (hit) flag <= 1'b1;
      else if (wr_ctl && armed && !reg_wdata[0]) flag <= 1'b0;
      if (wr_ctl) ie <= reg_wdata[1];
      if (rd_ctl && flag) armed <= 1'b1;
      else if (wr_ctl) armed <= 1'b0;
    end
  end

  assign irq       = flag & ie;
  assign reg_rdata = (reg_addr == SEL_CTL) ? {{(CNT_W-2){1'b0}}, ie, flag} : cnt;
endmodule

// File: rtl/dma_half_counter_chk.sv
module dma_half_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_addr,
  input logic             reg_wr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             xfer_done,
  input logic             nmi,
  input logic             addr_err,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             armed
);
  wire wr_cnt = reg_wr && !reg_addr;
  wire wr_ctl = reg_wr && reg_addr;

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !wr_cnt) |=> cnt == '0);

  a_r5_set_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(xfer_done));

  a_r6_abort_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ((nmi || addr_err) && !wr_cnt) |=> cnt == $past(cnt));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_ctl && !reg_wdata[0])) |=> flag);

  a_r8_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);

  a_r10_ie_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !reg_wdata[1]) |=> !irq);
endmodule

bind dma_half_counter dma_half_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .xfer_done(xfer_done), .nmi(nmi),
  .addr_err(addr_err), .irq(irq), .cnt(cnt), .flag(flag), .armed(armed)
);

// File: tb/dma_half_counter_test.sv
module dma_half_counter_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic chan_en = 0, mst_en = 1, xfer_done = 0, nmi = 0, addr_err = 0, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_half_counter #(.CNT_W(W)) uut (.*);

  // {start, strobes, expected count, expected flag}
  localparam int VEC [0:7][0:3] = '{
    '{10, 4, 6, 0}, '{10, 5, 5, 1}, '{11, 5, 6, 0}, '{11, 6, 5, 1},
    '{ 1, 1, 0, 1}, '{ 3, 5, 0, 1}, '{ 0, 2, 0, 0}, '{ 2, 1, 1, 1}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic a, int d);
    reg_addr = a; reg_wdata = W'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic a, output int d);
    reg_addr = a; reg_rd = 1; #1 d = int'(reg_rdata);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1; @(negedge clk); xfer_done = 0;
    end
  endtask

  task automatic pulse_abort(bit use_nmi);
    if (use_nmi) nmi = 1; else addr_err = 1;
    @(negedge clk); nmi = 0; addr_err = 0;
  endtask

  task automatic start_run(int c);
    chan_en = 0; @(negedge clk);
    wr(0, c);
    chan_en = 1; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (2) @(negedge clk);
    check("R1 count", int'(reg_rdata), 0);
    reg_addr = 1; #1;
    check("R1 ctl", int'(reg_rdata), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1; @(negedge clk);

    wr(0, 8'hA5); rd(0, v); check("R2 count readback", v, 8'hA5);

    for (int k = 0; k < 8; k++) begin
      rd(1, v); wr(1, 0);
      start_run(VEC[k][0]);
      strobe(VEC[k][1]);
      rd(0, v); check($sformatf("R3/R4 vec%0d count", k), v, VEC[k][2]);
      rd(1, v); check($sformatf("R5 vec%0d flag", k), v & 1, VEC[k][3]);
    end

    rd(1, v); wr(1, 0); rd(1, v); check("R8 cleared by read+write0", v, 0);

    // R3: no decrement while enables are low
    start_run(6);
    chan_en = 0; @(negedge clk); strobe(2);
    rd(0, v); check("R3 chan_en low holds", v, 6);
    start_run(6);
    mst_en = 0; @(negedge clk); strobe(2);
    rd(0, v); check("R3 mst_en low holds", v, 6);
    mst_en = 1;

    // R6: abort before half
    start_run(10);
    strobe(2); pulse_abort(1); strobe(5);
    rd(0, v); check("R6 nmi blocks count", v, 8);
    rd(1, v); check("R6 flag not set", v & 1, 0);
    chan_en = 0; @(negedge clk); chan_en = 1; @(negedge clk);
    strobe(3);
    rd(0, v); check("R6 restart count", v, 5);
    rd(1, v); check("R6 restart below half", v & 1, 0);
    strobe(1);
    rd(1, v); check("R5 half of relatched start", v & 1, 1);

    // R7: sticky through aborts
    pulse_abort(0); strobe(2);
    rd(0, v); check("R6 addr_err blocks", v, 4);
    rd(1, v); check("R7 flag after addr_err", v & 1, 1);
    mst_en = 0; @(negedge clk); mst_en = 1; chan_en = 0; @(negedge clk);
    rd(1, v); check("R7 flag after enables drop", v & 1, 1);

    // R8: clear handshake
    wr(1, 1);
    wr(1, 0);
    rd(1, v); check("R8 write0 without read ignored", v & 1, 1);
    wr(1, 0);
    rd(1, v); check("R8 read then write0 clears", v & 1, 0);
    wr(1, 1);
    rd(1, v); check("R8 write1 does not set", v & 1, 0);

    // R9/R10: interrupt
    wr(1, 3);
    check("R9 irq off with flag 0", int'(irq), 0);
    start_run(4); strobe(2);
    #1 check("R9 irq on", int'(irq), 1);
    wr(1, 1);
    check("R10 irq drops on ie=0", int'(irq), 0);
    wr(1, 3);
    check("R9 irq back on", int'(irq), 1);
    rd(1, v); wr(1, 2);
    check("R10 irq drops on flag clear", int'(irq), 0);
    rd(1, v); check("R9 ie kept", v, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule